// File: doc/BRIEF.md
# Mode-selectable panel timing generator

This block produces the raster timing for the input port of a small LCD: a pixel counter, a line counter, horizontal and vertical sync, a data-enable strobe and active-area coordinates. The geometry is not programmed field by field. A 4-bit format code picks one entry from a built-in table, and several entries have very uneven porches. Each sync and enable output has its own polarity input. A 2-bit sync selection turns each group of outputs on or off. Two direction inputs mirror the active-area coordinates horizontally and vertically.

The block advances by one pixel on each clock where the pixel enable is high. A new format code takes effect only at a frame boundary. After reset the block first passes through an idle state, so the first enabled clock loads the code that is present at that time. Codes without a table entry keep the block idle. Every output is registered. The counter outputs and the sync, enable and coordinate outputs always describe the same pixel.

Top module: `panel_timing_gen`

## Requirements
- R1: While rst_ni is low, every output is 0. The first enabled clock after reset loads mode_i. The second enabled clock presents pixel (0,0) of that mode on h_cnt_o/v_cnt_o.
- R2: h_cnt_o counts from 0 to line length minus 1, then wraps to 0. The line lengths by code are 0, 1 and 2: 921; 3: 637; 5 and 6: 409; 7: 921; 8: 997; 10: 996; 11: 916.
- R3: v_cnt_o advances when h_cnt_o wraps, and wraps after the last line of the frame. A frame is 262 lines for codes 0 to 3, 5 and 6, 343 for code 7, 383 for code 8, and 500 for codes 10 and 11.
- R4: HSYNC is active for exactly one pixel per line. That pixel is at h_cnt_o = 679 for codes 0 to 2, 395 for code 3, 358 for codes 5 and 6, 892 for code 7, 972 for code 8, 723 for code 10 and 643 for code 11.
- R5: VSYNC is active for one whole line. That line is 244 for codes 0 to 2, 5 and 6; 261 for code 3; 324 for code 7; 364 for code 8; 484 for codes 10 and 11.
- R6: DE is active when h_cnt_o is below the active width and v_cnt_o is below the active height. Width by height per code: 0 to 2: 320x240; 3: 360x240; 5 and 6: 320x240; 7: 640x320; 8: 720x360; 10: 720x480; 11: 640x480. DE is never active in the same pixel as HSYNC.
- R7: For each output, a polarity input of 1 makes the active level 1 and a polarity input of 0 makes the active level 0. An inactive output sits at the opposite level.
- R8: sync_sel_i selects which outputs can be active: 0 gives HSYNC and VSYNC, 1 gives HSYNC, VSYNC and DE, 2 gives DE only, and 3 gives none. Deselected outputs stay inactive.
- R9: In the active area, x_o = h_cnt_o when hdir_i=1 and x_o = width-1-h_cnt_o when hdir_i=0. Likewise y_o = v_cnt_o when vdir_i=1 and y_o = height-1-v_cnt_o when vdir_i=0. Outside the active area both coordinates are 0.
- R10: For codes 4, 9 and 12 to 15, the counters stay at 0 and all outputs stay inactive.
- R11: A change of mode_i during a frame leaves that frame's timing unchanged. The new code applies from the first pixel of the next frame.
- R12: On clocks where pix_en_i is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel advance enable |
| mode_i | input | 4 | Format code selecting the timing entry |
| sync_sel_i | input | 2 | Output group selection |
| hs_pol_i | input | 1 | HSYNC active level |
| vs_pol_i | input | 1 | VSYNC active level |
| de_pol_i | input | 1 | DE active level |
| hdir_i | input | 1 | Horizontal coordinate direction |
| vdir_i | input | 1 | Vertical coordinate direction |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| h_cnt_o | output | 10 | Pixel counter |
| v_cnt_o | output | 9 | Line counter |
| x_o | output | 10 | Active-area column coordinate |
| y_o | output | 9 | Active-area row coordinate |

## Verification
Two events can land in the same clock: a format-code change and the frame wrap that decides whether the new code is used. The bench provokes this by changing the code in the middle of a full parallel-mode frame. It then checks two things: every line of the running frame keeps the old 409-pixel length, and the line after the wrap takes the new 637-pixel length. The bench also measures, over a whole frame, the VSYNC line and the DE pixel count, and relies on the checker to confirm that DE never coincides with HSYNC.

// File: rtl/panel_timing_pkg.sv
package panel_timing_pkg;
  localparam int HW = 10;
  localparam int VW = 9;
  localparam int MW = 4;
  localparam logic [MW-1:0] MODE_IDLE = MW'(4);

  typedef struct packed {
    logic          valid;
    logic [HW-1:0] h_act;
    logic [HW-1:0] h_sync;
    logic [HW-1:0] h_sw;
    logic [HW-1:0] h_total;
    logic [VW-1:0] v_act;
    logic [VW-1:0] v_sync;
    logic [VW-1:0] v_sw;
    logic [VW-1:0] v_total;
  } tim_t;

  function automatic tim_t make_tim(input int ha, input int hfp, input int hsw, input int hbp,
                                    input int va, input int vfp, input int vsw, input int vbp);
    tim_t t;
    t.valid   = 1'b1;
    t.h_act   = HW'(ha);
    t.h_sync  = HW'(ha + hfp);
    t.h_sw    = HW'(hsw);
    t.h_total = HW'(ha + hfp + hsw + hbp);
    t.v_act   = VW'(va);
    t.v_sync  = VW'(va + vfp);
    t.v_sw    = VW'(vsw);
    t.v_total = VW'(va + vfp + vsw + vbp);
    return t;
  endfunction

  function automatic tim_t lookup_tim(input logic [MW-1:0] code);
    case (code)
      4'd0, 4'd1, 4'd2: return make_tim(320, 359, 1, 241, 240, 4, 1, 17);
      4'd3:             return make_tim(360, 35, 1, 241, 240, 21, 1, 0);
      4'd5, 4'd6:       return make_tim(320, 38, 1, 50, 240, 4, 1, 17);
      4'd7:             return make_tim(640, 252, 1, 28, 320, 4, 1, 18);
      4'd8:             return make_tim(720, 252, 1, 24, 360, 4, 1, 18);
      4'd10:            return make_tim(720, 3, 1, 272, 480, 4, 1, 15);
      4'd11:            return make_tim(640, 3, 1, 272, 480, 4, 1, 15);
      default:          return '0;
    endcase
  endfunction
endpackage

// File: rtl/panel_timing_axis.sv
module panel_timing_axis #(
  parameter int W = 10
) (
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] act_i,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] total_i,
  input  logic         dir_i,
  output logic         act_o,
  output logic         sync_o,
  output logic         last_o,
  output logic [W-1:0] coord_o
);
  localparam logic [W-1:0] ONE = W'(1);

  assign act_o   = cnt_i < act_i;
  assign sync_o  = (cnt_i >= sync_i) && (cnt_i < sync_i + sw_i);
  assign last_o  = cnt_i == total_i - ONE;
  // mirrored coordinate when scanning the reverse way
  assign coord_o = dir_i ? cnt_i : act_i - ONE - cnt_i;
endmodule

// File: rtl/panel_timing_ctr.sv
module panel_timing_ctr
  import panel_timing_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic [MW-1:0] mode_i,
  input  logic          valid_i,
  input  logic          h_last_i,
  input  logic          v_last_i,
  output logic [MW-1:0] mode_o,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  logic [MW-1:0] mode_q;
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          reload;

  // frame boundary, or idle: accept a new code
  assign reload = !valid_i || (h_last_i && v_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      h_q    <= '0;
      v_q    <= '0;
    end else if (pix_en_i) begin
      if (reload) begin
        mode_q <= mode_i;
        h_q    <= '0;
        v_q    <= '0;
      end else if (h_last_i) begin
        h_q <= '0;
        v_q <= v_q + VW'(1);
      end else begin
        h_q <= h_q + HW'(1);
      end
    end
  end

  assign mode_o = mode_q;
  assign h_o    = h_q;
  assign v_o    = v_q;
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import panel_timing_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pix_en_i,
  input  logic [MW-1:0] mode_i,
  input  logic [1:0]    sync_sel_i,
  input  logic          hs_pol_i,
  input  logic          vs_pol_i,
  input  logic          de_pol_i,
  input  logic          hdir_i,
  input  logic          vdir_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [HW-1:0] h_cnt_o,
  output logic [VW-1:0] v_cnt_o,
  output logic [HW-1:0] x_o,
  output logic [VW-1:0] y_o
);
  logic [MW-1:0] mode_q;
  logic [HW-1:0] h_q, hx;
  logic [VW-1:0] v_q, vy;
  tim_t          tim;
  logic          h_act, h_sync, h_last;
  logic          v_act, v_sync, v_last;
  logic          hv_en, de_en, de_raw, hs_raw, vs_raw;

  assign tim = lookup_tim(mode_q);

  panel_timing_ctr i_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pix_en_i (pix_en_i),
    .mode_i   (mode_i),
    .valid_i  (tim.valid),
    .h_last_i (h_last),
    .v_last_i (v_last),
    .mode_o   (mode_q),
    .h_o      (h_q),
    .v_o      (v_q)
  );

  panel_timing_axis #(.W(HW)) i_h_axis (
    .cnt_i   (h_q),
    .act_i   (tim.h_act),
    .sync_i  (tim.h_sync),
    .sw_i    (tim.h_sw),
    .total_i (tim.h_total),
    .dir_i   (hdir_i),
    .act_o   (h_act),
    .sync_o  (h_sync),
    .last_o  (h_last),
    .coord_o (hx)
  );

  panel_timing_axis #(.W(VW)) i_v_axis (
    .cnt_i   (v_q),
    .act_i   (tim.v_act),
    .sync_i  (tim.v_sync),
    .sw_i    (tim.v_sw),
    .total_i (tim.v_total),
    .dir_i   (vdir_i),
    .act_o   (v_act),
    .sync_o  (v_sync),
    .last_o  (v_last),
    .coord_o (vy)
  );

  assign hv_en  = (sync_sel_i == 2'd0) || (sync_sel_i == 2'd1);
  assign de_en  = (sync_sel_i == 2'd1) || (sync_sel_i == 2'd2);
  assign de_raw = tim.valid && h_act && v_act;
  assign hs_raw = tim.valid && h_sync;
  assign vs_raw = tim.valid && v_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      de_o    <= 1'b0;
      h_cnt_o <= '0;
      v_cnt_o <= '0;
      x_o     <= '0;
      y_o     <= '0;
    end else if (pix_en_i) begin
      hsync_o <= (hs_raw && hv_en) ? hs_pol_i : !hs_pol_i;
      vsync_o <= (vs_raw && hv_en) ? vs_pol_i : !vs_pol_i;
      de_o    <= (de_raw && de_en) ? de_pol_i : !de_pol_i;
      h_cnt_o <= h_q;
      v_cnt_o <= v_q;
      x_o     <= de_raw ? hx : '0;
      y_o     <= de_raw ? vy : '0;
    end
  end
endmodule

// File: rtl/panel_timing_chk.sv
module panel_timing_chk
  import panel_timing_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pix_en_i,
  input logic [1:0]    sync_sel_i,
  input logic          hs_pol_i,
  input logic          vs_pol_i,
  input logic          de_pol_i,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic [HW-1:0] h_cnt_o,
  input logic [VW-1:0] v_cnt_o
);
  logic seen_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_en <= 1'b0;
    else if (pix_en_i) seen_en <= 1'b1;
  end

  AST_PIX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |=> (h_cnt_o == $past(h_cnt_o) + HW'(1)) || (h_cnt_o == '0)); // R2

  AST_LINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_en_i |=> (h_cnt_o == '0) || $stable(v_cnt_o)); // R3

  AST_HS_ONE_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_en && pix_en_i && (hsync_o == hs_pol_i)) |=> (hsync_o != hs_pol_i)); // R4

  AST_DE_NOT_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_en && (de_o == de_pol_i)) |-> (hsync_o != hs_pol_i)); // R6

  AST_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && (sync_sel_i == 2'd3)) |=>
      (hsync_o != $past(hs_pol_i)) && (vsync_o != $past(vs_pol_i)) && (de_o != $past(de_pol_i))); // R8

  AST_DE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && (sync_sel_i == 2'd2)) |=>
      (hsync_o != $past(hs_pol_i)) && (vsync_o != $past(vs_pol_i))); // R8

  AST_NO_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && (sync_sel_i == 2'd0)) |=> (de_o != $past(de_pol_i))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(h_cnt_o) && $stable(v_cnt_o) && $stable(hsync_o)
                  && $stable(vsync_o) && $stable(de_o)); // R12
endmodule

bind panel_timing_gen panel_timing_chk i_chk (.*);

// File: tb/test_panel_timing_gen.sv
module test_panel_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en;
  logic [3:0] mode;
  logic [1:0] sync_sel;
  logic       hs_pol, vs_pol, de_pol, hdir, vdir;
  logic       hsync, vsync, de;
  logic [9:0] h_cnt, x;
  logic [8:0] v_cnt, y;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  panel_timing_gen i_panel_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .mode_i(mode),
    .sync_sel_i(sync_sel), .hs_pol_i(hs_pol), .vs_pol_i(vs_pol), .de_pol_i(de_pol),
    .hdir_i(hdir), .vdir_i(vdir), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .h_cnt_o(h_cnt), .v_cnt_o(v_cnt), .x_o(x), .y_o(y)
  );

  // {code, line length, hsync pixel (FFFF none), DE pixels on line 0}
  localparam logic [63:0] VEC [12] = '{
    {16'd0,  16'd921, 16'd679,   16'd320},
    {16'd2,  16'd921, 16'd679,   16'd320},
    {16'd3,  16'd637, 16'd395,   16'd360},
    {16'd5,  16'd409, 16'd358,   16'd320},
    {16'd6,  16'd409, 16'd358,   16'd320},
    {16'd7,  16'd921, 16'd892,   16'd640},
    {16'd8,  16'd997, 16'd972,   16'd720},
    {16'd10, 16'd996, 16'd723,   16'd720},
    {16'd11, 16'd916, 16'd643,   16'd640},
    {16'd4,  16'd1,   16'hFFFF,  16'd0},
    {16'd9,  16'd1,   16'hFFFF,  16'd0},
    {16'd13, 16'd1,   16'hFFFF,  16'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] code);
    rst_n = 1'b0;
    mode  = code;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_pos(input int h, input int v);
    int n;
    n = 0;
    @(negedge clk);
    while (!(int'(h_cnt) == h && (v < 0 || int'(v_cnt) == v)) && n < 150000) begin
      @(negedge clk);
      n++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 195000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 195000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_en = 1'b1; mode = 4'd5; sync_sel = 2'd1;
    hs_pol = 1'b1; vs_pol = 1'b1; de_pol = 1'b1; hdir = 1'b1; vdir = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(h_cnt == 0 && v_cnt == 0 && x == 0 && y == 0, "R1 counters in reset", int'(h_cnt) + int'(v_cnt), 0);
    chk({hsync, vsync, de} == 3'b000, "R1 syncs in reset", int'({hsync, vsync, de}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(h_cnt == 0 && v_cnt == 0 && de == 1'b1, "R1 first pixel", int'(de), 1);
    @(negedge clk);
    chk(h_cnt == 1, "R2 pixel step", int'(h_cnt), 1);

    // table walk: R2 line length, R4 hsync pixel, R6 DE width, R10 idle codes
    for (int i = 0; i < 12; i++) begin
      int mx, hs, dc;
      logic [63:0] vv;
      vv = VEC[i];
      do_reset(vv[51:48]);
      mx = 0; hs = 65535; dc = 0;
      repeat (2100) begin
        @(negedge clk);
        if (int'(h_cnt) > mx) mx = int'(h_cnt);
        if (hsync && hs == 65535) hs = int'(h_cnt);
        if (de && v_cnt == 0) dc++;
      end
      if (vv[15:0] == 16'd0) begin
        chk(mx == 0, "R10 idle counter", mx, 0);
        chk(hs == 65535, "R10 idle hsync", hs, 65535);
        chk(dc == 0, "R10 idle de", dc, 0);
      end else begin
        chk(mx + 1 == int'(vv[47:32]), "R2 line length", mx + 1, int'(vv[47:32]));
        chk(hs == int'(vv[31:16]), "R4 hsync pixel", hs, int'(vv[31:16]));
        chk(dc == int'(vv[15:0]), "R6 de width", dc, int'(vv[15:0]));
      end
    end

    // R7 polarity, all active low
    hs_pol = 1'b0; vs_pol = 1'b0; de_pol = 1'b0;
    do_reset(4'd5);
    wait_pos(5, 0);
    chk(de == 1'b0, "R7 de active low", int'(de), 0);
    chk(hsync == 1'b1 && vsync == 1'b1, "R7 syncs idle high", int'({hsync, vsync}), 3);
    wait_pos(358, -1);
    chk(hsync == 1'b0, "R7 hsync active low", int'(hsync), 0);
    hs_pol = 1'b1; vs_pol = 1'b1; de_pol = 1'b1;

    // R8 sync selection
    do_reset(4'd5);
    sync_sel = 2'd0;
    wait_pos(10, -1);
    chk(de == 1'b0, "R8 sel0 de off", int'(de), 0);
    wait_pos(358, -1);
    chk(hsync == 1'b1, "R8 sel0 hsync on", int'(hsync), 1);
    sync_sel = 2'd2;
    wait_pos(10, -1);
    chk(de == 1'b1, "R8 sel2 de on", int'(de), 1);
    wait_pos(358, -1);
    chk(hsync == 1'b0, "R8 sel2 hsync off", int'(hsync), 0);
    sync_sel = 2'd3;
    wait_pos(10, -1);
    chk({hsync, vsync, de} == 3'b000, "R8 sel3 all off", int'({hsync, vsync, de}), 0);
    wait_pos(358, -1);
    chk(hsync == 1'b0, "R8 sel3 hsync off", int'(hsync), 0);
    sync_sel = 2'd1;

    // R9 coordinates
    hdir = 1'b0; vdir = 1'b0;
    do_reset(4'd5);
    wait_pos(3, 0);
    chk(x == 316 && y == 239, "R9 mirrored origin", int'(x) * 1000 + int'(y), 316239);
    wait_pos(2, 1);
    chk(x == 317 && y == 238, "R9 mirrored step", int'(x) * 1000 + int'(y), 317238);
    wait_pos(330, -1);
    chk(x == 0 && y == 0, "R9 blank coords", int'(x) + int'(y), 0);
    hdir = 1'b1; vdir = 1'b1;
    do_reset(4'd5);
    wait_pos(7, 2);
    chk(x == 7 && y == 2, "R9 forward coords", int'(x) * 1000 + int'(y), 7002);

    // R12 pause
    wait_pos(50, -1);
    pix_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(h_cnt == 50 && de == 1'b1, "R12 hold while paused", int'(h_cnt), 50);
    pix_en = 1'b1;
    @(negedge clk);
    chk(h_cnt == 51, "R12 resume", int'(h_cnt), 51);

    // full frame: R3, R5, R6 and R11 (code changed mid-frame)
    begin
      int mxv, mxh, vsl, vsc, dcn, pv, n, mx2;
      bit done, sw;
      do_reset(4'd5);
      mxv = 0; mxh = 0; vsl = -1; vsc = 0; dcn = 0; pv = 0; n = 0; done = 0; sw = 0;
      while (!done && n < 120000) begin
        @(negedge clk);
        n++;
        if (pv == 261 && v_cnt == 0) done = 1;
        else begin
          if (int'(v_cnt) > mxv) mxv = int'(v_cnt);
          if (int'(h_cnt) > mxh) mxh = int'(h_cnt);
          if (vsync) begin
            vsc++;
            if (vsl < 0) vsl = int'(v_cnt);
          end
          if (de) dcn++;
          if (!sw && v_cnt == 100) begin
            mode = 4'd3;
            sw = 1;
          end
        end
        pv = int'(v_cnt);
      end
      chk(mxv + 1 == 262, "R3 frame length", mxv + 1, 262);
      chk(vsl == 244, "R5 vsync line", vsl, 244);
      chk(vsc == 409, "R5 vsync width", vsc, 409);
      chk(dcn == 76800, "R6 de per frame", dcn, 76800);
      chk(mxh == 408, "R11 old timing kept", mxh, 408);
      mx2 = int'(h_cnt);
      n = 0;
      while (v_cnt == 0 && n < 2000) begin
        @(negedge clk);
        n++;
        if (v_cnt == 0 && int'(h_cnt) > mx2) mx2 = int'(h_cnt);
      end
      chk(mx2 == 636, "R11 new timing next frame", mx2 + 1, 637);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule